// File: doc/BRIEF.md
# Display Controller Command Byte Interpreter

This block sits behind a serial slave front end and turns its received byte stream into framebuffer writes and display state for a monochrome, page-organised display controller of 132 columns by 8 pages. Each byte arrives with a one-cycle valid strobe. The front end also reports transfer start and transfer stop events. A transfer opens with a control byte that selects either a command or a pixel data stream. Pixel data bytes are written through a registered write port. Command bytes update the column, page, start line and four display flags, which are held on the outputs.

The interpreter is a four-state machine:
- IDLE waits for a control byte. 0x80 takes the transition IDLE→CMD, 0x40 takes IDLE→DATA, and any other byte is an error.
- CMD executes one opcode. An opcode that takes an argument moves CMD→ARG. Every other opcode, including an unknown one, returns CMD→IDLE.
- ARG discards exactly one byte and returns ARG→IDLE.
- DATA writes every byte and stays in DATA.

A start or stop event takes the transition ANY→IDLE.

Top module: `oled_cmd_interp`

## Requirements
- R1: After reset, col, page, start_line, mirror, all_on, inverse, disp_en, fb_we and err are all zero, and the machine is in IDLE.
- R2: In IDLE, byte 0x80 enters command mode and byte 0x40 enters data mode. Any other byte raises err for exactly one cycle, changes no state and leaves the machine in IDLE.
- R3: In data mode, each byte produces a one-cycle fb_we in the cycle after it is accepted. fb_addr equals col + page*132 and fb_wdata equals the byte. Data mode persists for following bytes.
- R4: After each data byte the column increments by one, holds at 131 once it reaches 131, and the page never changes.
- R5: Opcodes 0x00 to 0x0F replace col[3:0] with the opcode's low nibble.
- R6: Opcodes 0x10 to 0x1F replace col[7:4] with the opcode's low nibble.
- R7: Opcodes 0x40 to 0x7F set start_line to the opcode's low 6 bits. Opcodes 0xB0 to 0xBF set page to the opcode's low 3 bits.
- R8: Opcodes 0x81, 0xA8, 0xAD, 0xD3, 0xD5, 0xD8, 0xD9, 0xDA and 0xDB consume the next byte whatever its value. That byte is discarded and the machine then returns to IDLE.
- R9: Opcodes 0xA0/0xA1 clear/set mirror, 0xA4/0xA5 clear/set all_on, 0xA6/0xA7 clear/set inverse, and 0xAE/0xAF clear/set disp_en.
- R10: Opcodes 0xC0 to 0xC8 and 0xE3 change nothing and raise no error.
- R11: After any opcode that takes no argument, the machine returns to IDLE, so the next byte is read as a control byte.
- R12: A start or stop event forces IDLE. A byte accepted in the same cycle as an event is dropped: it causes no write, no error and no state change.
- R13: An opcode outside every listed range raises err for one cycle, leaves all state unchanged and returns to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte is valid this cycle |
| rx_byte | input | 8 | Received byte |
| bus_start | input | 1 | Transfer start event |
| bus_stop | input | 1 | Transfer stop event |
| fb_we | output | 1 | Framebuffer write strobe |
| fb_addr | output | 11 | Framebuffer byte address |
| fb_wdata | output | 8 | Framebuffer write data |
| col | output | 8 | Column address |
| page | output | 3 | Page address |
| start_line | output | 6 | Display start line |
| mirror | output | 1 | Horizontal mirror flag |
| all_on | output | 1 | Entire display on flag |
| inverse | output | 1 | Inverse video flag |
| disp_en | output | 1 | Display enable |
| err | output | 1 | One-cycle error pulse |

## Verification
Two functions can land in the same cycle: a valid byte and a start or stop event. The event must win, and the byte must be lost without trace. The bench provokes this by presenting a data byte with bus_start raised while in data mode. It then requires that no write and no error follow, that the column is unchanged, and that the next byte is read as a control byte. The same collision is also driven in the argument state, where the event must end the skip before the byte can be swallowed.

// File: rtl/oled_cmd_pkg.sv
package oled_cmd_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] CTRL_CMD  = 8'h80;
    localparam logic [BYTE_W-1:0] CTRL_DATA = 8'h40;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_ARG
    } mode_e;

    typedef enum logic [2:0] {
        OP_COL_LO,
        OP_COL_HI,
        OP_START,
        OP_PAGE,
        OP_FLAG,
        OP_SKIP,
        OP_NOP,
        OP_BAD
    } op_cls_e;

    typedef enum logic [1:0] {
        FL_MIRROR,
        FL_ALLON,
        FL_INVERSE,
        FL_ENABLE
    } flag_e;

    typedef struct packed {
        op_cls_e    cls;
        flag_e      flag;
        logic       val;
        logic [5:0] arg;
    } op_dec_t;

endpackage

// File: rtl/oled_op_decode.sv
module oled_op_decode
    import oled_cmd_pkg::*;
(
    input  logic [BYTE_W-1:0] op,
    output op_dec_t           dec
);

    always_comb begin
        dec.cls  = OP_BAD;
        dec.flag = FL_MIRROR;
        dec.val  = op[0];
        dec.arg  = op[5:0];
        if (op[7:4] == 4'h0) begin
            dec.cls = OP_COL_LO;
        end else if (op[7:4] == 4'h1) begin
            dec.cls = OP_COL_HI;
        end else if (op[7:6] == 2'b01) begin
            dec.cls = OP_START;
        end else if (op[7:4] == 4'hB) begin
            dec.cls = OP_PAGE;
        end else if (op >= 8'hC0 && op <= 8'hC8) begin
            dec.cls = OP_NOP;
        end else begin
            case (op)
                8'hE3: dec.cls = OP_NOP;
                8'h81, 8'hA8, 8'hAD, 8'hD3, 8'hD5,
                8'hD8, 8'hD9, 8'hDA, 8'hDB: dec.cls = OP_SKIP;
                8'hA0, 8'hA1: begin dec.cls = OP_FLAG; dec.flag = FL_MIRROR;  end
                8'hA4, 8'hA5: begin dec.cls = OP_FLAG; dec.flag = FL_ALLON;   end
                8'hA6, 8'hA7: begin dec.cls = OP_FLAG; dec.flag = FL_INVERSE; end
                8'hAE, 8'hAF: begin dec.cls = OP_FLAG; dec.flag = FL_ENABLE;  end
                default:      dec.cls = OP_BAD;
            endcase
        end
    end

endmodule

// File: rtl/oled_mode_fsm.sv
module oled_mode_fsm
    import oled_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  op_dec_t           dec,
    output logic              cmd_go,
    output logic              data_wr,
    output logic              ctrl_err
);

    mode_e state, state_nx;
    logic  evt;

    assign evt = bus_start | bus_stop;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        cmd_go   = 1'b0;
        data_wr  = 1'b0;
        ctrl_err = 1'b0;
        if (evt) begin
            state_nx = ST_IDLE;
        end else if (rx_valid) begin
            unique case (state)
                ST_IDLE: begin
                    if (rx_byte == CTRL_CMD)       state_nx = ST_CMD;
                    else if (rx_byte == CTRL_DATA) state_nx = ST_DATA;
                    else                           ctrl_err = 1'b1;
                end
                ST_CMD: begin
                    cmd_go   = 1'b1;
                    state_nx = (dec.cls == OP_SKIP) ? ST_ARG : ST_IDLE;
                end
                ST_DATA: data_wr  = 1'b1;
                ST_ARG:  state_nx = ST_IDLE;
            endcase
        end
    end

    AST_EVENT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (state == ST_IDLE)); // R12
    AST_ARG_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARG && rx_valid && !evt) |=> (state == ST_IDLE)); // R8
    AST_CMD_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMD && rx_valid && !evt && dec.cls != OP_SKIP) |=> (state == ST_IDLE)); // R11
    AST_DATA_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && !evt) |=> (state == ST_DATA)); // R3

endmodule

// File: rtl/oled_disp_regs.sv
module oled_disp_regs
    import oled_cmd_pkg::*;
#(
    parameter int NUM_COLS  = 132,
    parameter int NUM_PAGES = 8,
    parameter int LINE_W    = 6,
    parameter int PAGE_W    = $clog2(NUM_PAGES),
    parameter int ADDR_W    = $clog2(256 + (NUM_PAGES - 1) * NUM_COLS)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_go,
    input  logic              data_wr,
    input  logic              ctrl_err,
    input  op_dec_t           dec,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              fb_we,
    output logic [ADDR_W-1:0] fb_addr,
    output logic [BYTE_W-1:0] fb_wdata,
    output logic [BYTE_W-1:0] col,
    output logic [PAGE_W-1:0] page,
    output logic [LINE_W-1:0] start_line,
    output logic              mirror,
    output logic              all_on,
    output logic              inverse,
    output logic              disp_en,
    output logic              err
);

    localparam logic [BYTE_W-1:0] COL_LAST = BYTE_W'(NUM_COLS - 1);

    logic bad_op;
    assign bad_op = cmd_go && (dec.cls == OP_BAD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col        <= '0;
            page       <= '0;
            start_line <= '0;
            mirror     <= 1'b0;
            all_on     <= 1'b0;
            inverse    <= 1'b0;
            disp_en    <= 1'b0;
        end else if (data_wr) begin
            if (col < COL_LAST) col <= col + 1'b1;
        end else if (cmd_go) begin
            unique case (dec.cls)
                OP_COL_LO: col        <= {col[7:4], dec.arg[3:0]};
                OP_COL_HI: col        <= {dec.arg[3:0], col[3:0]};
                OP_START:  start_line <= dec.arg[LINE_W-1:0];
                OP_PAGE:   page       <= dec.arg[PAGE_W-1:0];
                OP_FLAG: begin
                    unique case (dec.flag)
                        FL_MIRROR:  mirror  <= dec.val;
                        FL_ALLON:   all_on  <= dec.val;
                        FL_INVERSE: inverse <= dec.val;
                        FL_ENABLE:  disp_en <= dec.val;
                    endcase
                end
                OP_SKIP, OP_NOP, OP_BAD: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fb_we    <= 1'b0;
            fb_addr  <= '0;
            fb_wdata <= '0;
            err      <= 1'b0;
        end else begin
            fb_we <= data_wr;
            err   <= ctrl_err | bad_op;
            if (data_wr) begin
                fb_addr  <= ADDR_W'(col) + ADDR_W'(page) * ADDR_W'(NUM_COLS);
                fb_wdata <= rx_byte;
            end
        end
    end

    AST_COL_HOLDS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && col == COL_LAST) |=> (col == COL_LAST)); // R4
    AST_PAGE_KEPT_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> $stable(page)); // R4
    AST_WE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> (fb_we && fb_wdata == $past(rx_byte))); // R3
    AST_BAD_OP_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        bad_op |=> (err && $stable(col) && $stable(page) && $stable(start_line)
                    && $stable(mirror) && $stable(inverse))); // R13
    AST_CTRL_ERR_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_err |=> (err && !fb_we && $stable(col) && $stable(disp_en))); // R2

endmodule

// File: rtl/oled_cmd_interp.sv
module oled_cmd_interp
    import oled_cmd_pkg::*;
#(
    parameter int NUM_COLS  = 132,
    parameter int NUM_PAGES = 8,
    parameter int LINE_W    = 6,
    parameter int PAGE_W    = $clog2(NUM_PAGES),
    parameter int ADDR_W    = $clog2(256 + (NUM_PAGES - 1) * NUM_COLS)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              bus_start,
    input  logic              bus_stop,
    output logic              fb_we,
    output logic [ADDR_W-1:0] fb_addr,
    output logic [7:0]        fb_wdata,
    output logic [7:0]        col,
    output logic [PAGE_W-1:0] page,
    output logic [LINE_W-1:0] start_line,
    output logic              mirror,
    output logic              all_on,
    output logic              inverse,
    output logic              disp_en,
    output logic              err
);

    op_dec_t dec;
    logic    cmd_go, data_wr, ctrl_err;

    oled_op_decode i_decode (
        .op  (rx_byte),
        .dec (dec)
    );

    oled_mode_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .dec       (dec),
        .cmd_go    (cmd_go),
        .data_wr   (data_wr),
        .ctrl_err  (ctrl_err)
    );

    oled_disp_regs #(
        .NUM_COLS  (NUM_COLS),
        .NUM_PAGES (NUM_PAGES),
        .LINE_W    (LINE_W),
        .PAGE_W    (PAGE_W),
        .ADDR_W    (ADDR_W)
    ) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_go     (cmd_go),
        .data_wr    (data_wr),
        .ctrl_err   (ctrl_err),
        .dec        (dec),
        .rx_byte    (rx_byte),
        .fb_we      (fb_we),
        .fb_addr    (fb_addr),
        .fb_wdata   (fb_wdata),
        .col        (col),
        .page       (page),
        .start_line (start_line),
        .mirror     (mirror),
        .all_on     (all_on),
        .inverse    (inverse),
        .disp_en    (disp_en),
        .err        (err)
    );

    AST_ERR_NOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !fb_we); // R13

endmodule

// File: tb/test_oled_cmd_interp.sv
`timescale 1ns/1ps
module test_oled_cmd_interp;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        bus_start = 1'b0;
    logic        bus_stop = 1'b0;
    logic        fb_we;
    logic [10:0] fb_addr;
    logic [7:0]  fb_wdata;
    logic [7:0]  col;
    logic [2:0]  page;
    logic [5:0]  start_line;
    logic        mirror, all_on, inverse, disp_en, err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [7:0] e_col;
    logic [2:0] e_page;
    logic [5:0] e_line;
    logic       e_mir, e_all, e_inv, e_en;

    always #2.5 clk = ~clk;

    oled_cmd_interp i_oled_cmd_interp (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .bus_start(bus_start), .bus_stop(bus_stop), .fb_we(fb_we),
        .fb_addr(fb_addr), .fb_wdata(fb_wdata), .col(col), .page(page),
        .start_line(start_line), .mirror(mirror), .all_on(all_on),
        .inverse(inverse), .disp_en(disp_en), .err(err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_state(input string tag);
        chk({tag, " col"}, col, e_col);
        chk({tag, " page"}, page, e_page);
        chk({tag, " start_line"}, start_line, e_line);
        chk({tag, " flags"}, {mirror, all_on, inverse, disp_en}, {e_mir, e_all, e_inv, e_en});
    endtask

    task automatic put(input logic [7:0] b, input logic st = 1'b0, input logic sp = 1'b0);
        @(negedge clk);
        rx_byte = b; rx_valid = 1'b1; bus_start = st; bus_stop = sp;
        @(negedge clk);
        rx_valid = 1'b0; bus_start = 1'b0; bus_stop = 1'b0;
    endtask

    task automatic evt_stop();
        @(negedge clk);
        bus_stop = 1'b1;
        @(negedge clk);
        bus_stop = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] op);
        put(8'h80);
        put(op);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        e_col = 0; e_page = 0; e_line = 0; e_mir = 0; e_all = 0; e_inv = 0; e_en = 0;
        chk_state("R1 reset");
        chk("R1 fb_we", fb_we, 0);
        chk("R1 err", err, 0);
    endtask

    task automatic t_ctrl_err();
        put(8'h55);
        chk("R2 err on non-control byte", err, 1);
        @(negedge clk);
        chk("R2 err lasts one cycle", err, 0);
        put(8'hAF);
        chk("R2 opcode in idle is error", err, 1);
        chk("R2 opcode in idle ignored", disp_en, 0);
        chk_state("R2 no state change");
    endtask

    task automatic t_flags();
        cmd(8'hAF); e_en = 1;
        chk("R9 disp_en set err", err, 0);
        cmd(8'hA1); e_mir = 1;
        cmd(8'hA5); e_all = 1;
        cmd(8'hA7); e_inv = 1;
        chk_state("R9 all flags set");
        cmd(8'hA0); e_mir = 0;
        chk_state("R9 mirror clear");
        cmd(8'hA4); e_all = 0;
        chk_state("R9 all_on clear");
        cmd(8'hAE); e_en = 0;
        chk_state("R9 disp_en clear");
        put(8'hA6);
        chk("R11 second opcode without control byte is error", err, 1);
        chk_state("R11 inverse kept");
        cmd(8'hA6); e_inv = 0;
        chk_state("R9 inverse clear");
    endtask

    task automatic t_addr();
        cmd(8'h05); e_col = 8'h05;
        chk_state("R5 low nibble");
        cmd(8'h1A); e_col = 8'hA5;
        chk_state("R6 high nibble");
        cmd(8'h0C); e_col = 8'hAC;
        chk_state("R5 low nibble keeps high");
        cmd(8'hB2); e_page = 2;
        chk_state("R7 page");
        cmd(8'hBF); e_page = 7;
        chk_state("R7 page low bits");
        cmd(8'h7F); e_line = 63;
        chk_state("R7 start line max");
        cmd(8'h45); e_line = 5;
        chk_state("R7 start line");
    endtask

    task automatic t_data();
        cmd(8'h00); cmd(8'h11); e_col = 8'h10;
        cmd(8'hB3); e_page = 3;
        put(8'h40);
        chk("R2 data control no err", err, 0);
        put(8'hD0);
        chk("R3 fb_we", fb_we, 1);
        chk("R3 fb_addr", fb_addr, 16 + 3 * 132);
        chk("R3 fb_wdata", fb_wdata, 8'hD0);
        @(negedge clk);
        chk("R3 fb_we one cycle", fb_we, 0);
        put(8'hD1);
        chk("R3 data mode persists", fb_we, 1);
        chk("R3 fb_addr second", fb_addr, 17 + 3 * 132);
        chk("R4 col incremented", col, 8'h12);
        chk("R4 page kept", page, 3);
        evt_stop(); e_col = 8'h12;
    endtask

    task automatic t_saturate();
        cmd(8'h02); cmd(8'h18); e_col = 8'd130;
        cmd(8'hB1); e_page = 1;
        put(8'h40);
        put(8'h11);
        chk("R3 addr 130 page 1", fb_addr, 130 + 132);
        put(8'h22);
        chk("R4 addr at last column", fb_addr, 131 + 132);
        put(8'h33);
        chk("R4 addr saturated", fb_addr, 131 + 132);
        chk("R4 wdata", fb_wdata, 8'h33);
        e_col = 8'd131;
        chk_state("R4 col saturated page kept");
        evt_stop();
    endtask

    task automatic t_skip();
        cmd(8'h81);
        put(8'h40);
        chk("R8 argument causes no err", err, 0);
        put(8'hAA);
        chk("R8 after argument idle err", err, 1);
        chk("R8 argument 0x40 not data", fb_we, 0);
        cmd(8'hD3);
        put(8'h80);
        put(8'hA7);
        chk("R8 argument 0x80 discarded", err, 1);
        chk_state("R8 state unchanged");
        cmd(8'hDB);
        put(8'hAF);
        chk_state("R8 argument opcode not run");
    endtask

    task automatic t_nop();
        cmd(8'hC4);
        chk("R10 nop no err", err, 0);
        cmd(8'hC8);
        cmd(8'hE3);
        chk("R10 E3 no err", err, 0);
        chk_state("R10 no effect");
        put(8'h40);
        chk("R11 idle after nop", err, 0);
        put(8'h5A);
        chk("R11 data after nop", fb_we, 1);
        e_col = e_col;
        evt_stop();
    endtask

    task automatic t_bad();
        cmd(8'h20);
        chk("R13 0x20 err", err, 1);
        chk_state("R13 0x20 no change");
        @(negedge clk);
        chk("R13 err one cycle", err, 0);
        cmd(8'hFF);
        chk("R13 0xFF err", err, 1);
        chk_state("R13 0xFF no change");
        put(8'hA7);
        chk("R13 idle after bad op", err, 1);
    endtask

    task automatic t_event();
        put(8'h40);
        evt_stop();
        put(8'h12);
        chk("R12 stop returns to idle", err, 1);
        chk("R12 no write after stop", fb_we, 0);
        put(8'h40);
        put(8'h77, 1'b1, 1'b0);
        chk("R12 coincident byte no write", fb_we, 0);
        chk("R12 coincident byte no err", err, 0);
        chk_state("R12 coincident byte no change");
        put(8'h40);
        chk("R12 idle after start", err, 0);
        put(8'h66);
        chk("R12 data resumes", fb_we, 1);
        chk("R12 data value", fb_wdata, 8'h66);
        if (e_col < 131) e_col = e_col + 1;
        put(8'h80, 1'b0, 1'b1);
        cmd(8'hA8);
        put(8'hAF, 1'b1, 1'b0);
        put(8'h80);
        put(8'hAF);
        e_en = 1;
        chk_state("R12 event ends argument skip");
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            errors++;
            $display("FAIL watchdog all actual=%0d expected=<100000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_ctrl_err();
        t_flags();
        t_addr();
        t_data();
        t_saturate();
        t_skip();
        t_nop();
        t_bad();
        t_event();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule